// File: doc/BRIEF.md
# USB Device Address Staging Register

This block holds the device address that a USB device controller answers to. Software updates it with a 32-bit word written over a simple register bus. The active 7-bit address drives the packet decoder. The same word can be read back at any time.

A write can take effect in one of two ways. In the first, the new address becomes active on the next clock. In the second, the new address is only staged. It becomes active after the next control IN transaction on endpoint 0 completes, which is the status stage of a SET_ADDRESS request. The protocol engine signals a completed IN transaction with a one-cycle strobe and the endpoint number. A USB bus reset returns the device to address 0 and drops any staged value.

Top module: `usb_addr_stage`

## Requirements
- R1: After rst_ni is asserted, dev_addr_o is 0, pending_o is 0 and rd_data_o is 0.
- R2: A write to byte offset 0x144 with bit 24 = 0 makes bits 31:25 of the written word the active address on the next clock, and it clears any pending state.
- R3: A write to offset 0x144 with bit 24 = 1 leaves the active address unchanged, stores bits 31:25 as the pending address and sets pending_o.
- R4: When a staged address is pending, a cycle with in_done_i = 1 and in_ep_i = 0 makes the pending address active on the next clock and clears pending_o.
- R5: in_done_i with in_ep_i not equal to 0 changes neither the active address nor the pending state.
- R6: A second staged write before the commit replaces the earlier pending address.
- R7: bus_reset_i = 1 clears the active address to 0 and discards the pending address on the next clock. It takes priority over writes and commits.
- R8: rd_data_o carries the active address in bits 31:25 and the pending flag in bit 24. Bits 23:0 always read 0.
- R9: A write at any offset other than 0x144 has no effect.
- R10: If a register write and a qualifying endpoint-0 IN completion occur in the same cycle, the write is applied and the commit is dropped.
- R11: in_done_i on endpoint 0 with nothing pending leaves the active address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_reset_i | input | 1 | USB bus reset strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_off_i | input | 12 | Byte offset of the write |
| wr_data_i | input | 32 | Write data |
| in_done_i | input | 1 | Strobe: IN transaction completed |
| in_ep_i | input | 4 | Endpoint number of the completed IN transaction |
| dev_addr_o | output | 7 | Active device address |
| pending_o | output | 1 | A staged address awaits commit |
| rd_data_o | output | 32 | Register read-back word |

## Verification
The assertions check the following on every cycle: immediate writes, staged writes, endpoint-0 commits, bus-reset clearing, the no-effect rule for other endpoints, and the layout of the read-back word. Some behaviours need a sequence of events to show. These are that a later staged value replaces an earlier one, that a commit with nothing pending changes nothing, that writes to other offsets are ignored, and that a write wins over a commit in the same cycle. Only the bench's ordered scenarios show these.

// File: rtl/usb_addr_pkg.sv
package usb_addr_pkg;
  localparam int unsigned ADDR_W    = 7;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_LSB  = 25;
  localparam int unsigned STAGE_BIT = 24;

  typedef struct packed {
    logic              hit;
    logic              stage;
    logic [ADDR_W-1:0] addr;
  } wr_evt_t;
endpackage

// File: rtl/usb_addr_wr_dec.sv
module usb_addr_wr_dec
  import usb_addr_pkg::*;
#(
  parameter int unsigned OFF_W  = 12,
  parameter logic [OFF_W-1:0] REG_OFF = 12'h144
) (
  input  logic              wr_en_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output wr_evt_t           evt_o
);
  logic unused_low;
  assign unused_low = ^wr_data_i[STAGE_BIT-1:0];

  always_comb begin
    evt_o.hit   = wr_en_i && (wr_off_i == REG_OFF);
    evt_o.stage = wr_data_i[STAGE_BIT];
    evt_o.addr  = wr_data_i[ADDR_LSB +: ADDR_W];
  end
endmodule

// File: rtl/usb_addr_commit.sv
module usb_addr_commit #(
  parameter int unsigned EP_W = 4
) (
  input  logic            in_done_i,
  input  logic [EP_W-1:0] in_ep_i,
  input  logic            pending_i,
  input  logic            wr_hit_i,
  input  logic            bus_reset_i,
  output logic            commit_o
);
  // write and bus reset take precedence over a commit
  always_comb
    commit_o = in_done_i && (in_ep_i == '0) && pending_i && !wr_hit_i && !bus_reset_i;
endmodule

// File: rtl/usb_addr_stage.sv
module usb_addr_stage
  import usb_addr_pkg::*;
#(
  parameter int unsigned OFF_W  = 12,
  parameter logic [OFF_W-1:0] REG_OFF = 12'h144,
  parameter int unsigned EP_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_reset_i,
  input  logic              wr_en_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              in_done_i,
  input  logic [EP_W-1:0]   in_ep_i,
  output logic [ADDR_W-1:0] dev_addr_o,
  output logic              pending_o,
  output logic [DATA_W-1:0] rd_data_o
);
  wr_evt_t           evt;
  logic              commit;
  logic [ADDR_W-1:0] act_q, pend_addr_q;
  logic              pend_q;

  usb_addr_wr_dec #(.OFF_W(OFF_W), .REG_OFF(REG_OFF)) u_dec (
    .wr_en_i  (wr_en_i),
    .wr_off_i (wr_off_i),
    .wr_data_i(wr_data_i),
    .evt_o    (evt)
  );

  usb_addr_commit #(.EP_W(EP_W)) u_commit (
    .in_done_i  (in_done_i),
    .in_ep_i    (in_ep_i),
    .pending_i  (pend_q),
    .wr_hit_i   (evt.hit),
    .bus_reset_i(bus_reset_i),
    .commit_o   (commit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q       <= '0;
      pend_addr_q <= '0;
      pend_q      <= 1'b0;
    end else if (bus_reset_i) begin
      act_q       <= '0;
      pend_addr_q <= '0;
      pend_q      <= 1'b0;
    end else if (evt.hit) begin
      if (evt.stage) begin
        pend_addr_q <= evt.addr;
        pend_q      <= 1'b1;
      end else begin
        act_q  <= evt.addr;
        pend_q <= 1'b0;
      end
    end else if (commit) begin
      act_q  <= pend_addr_q;
      pend_q <= 1'b0;
    end
  end

  assign dev_addr_o = act_q;
  assign pending_o  = pend_q;

  always_comb begin
    rd_data_o                       = '0;
    rd_data_o[ADDR_LSB +: ADDR_W]   = act_q;
    rd_data_o[STAGE_BIT]            = pend_q;
  end
endmodule

// File: rtl/usb_addr_stage_chk.sv
module usb_addr_stage_chk
  import usb_addr_pkg::*;
#(
  parameter int unsigned OFF_W  = 12,
  parameter logic [OFF_W-1:0] REG_OFF = 12'h144,
  parameter int unsigned EP_W   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_reset_i,
  input logic              wr_en_i,
  input logic [OFF_W-1:0]  wr_off_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              in_done_i,
  input logic [EP_W-1:0]   in_ep_i,
  input logic [ADDR_W-1:0] dev_addr_o,
  input logic              pending_o,
  input logic [DATA_W-1:0] rd_data_o
);
  logic hit;
  assign hit = wr_en_i && (wr_off_i == REG_OFF);

  assert_imm_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && !wr_data_i[STAGE_BIT] && !bus_reset_i
    |=> dev_addr_o == $past(wr_data_i[ADDR_LSB +: ADDR_W]) && !pending_o);

  assert_stage_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && wr_data_i[STAGE_BIT] && !bus_reset_i
    |=> pending_o && $stable(dev_addr_o));

  assert_commit_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_done_i && in_ep_i == '0 && pending_o && !wr_en_i && !bus_reset_i
    |=> !pending_o);

  assert_other_ep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_done_i && in_ep_i != '0 && !wr_en_i && !bus_reset_i
    |=> $stable(dev_addr_o) && $stable(pending_o));

  assert_bus_reset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> dev_addr_o == '0 && !pending_o);

  always_comb begin
    if (rst_ni) begin
      assert_readback_R8: assert (rd_data_o[ADDR_LSB +: ADDR_W] == dev_addr_o &&
                                  rd_data_o[STAGE_BIT] == pending_o &&
                                  rd_data_o[STAGE_BIT-1:0] == '0);
    end
  end
endmodule

bind usb_addr_stage usb_addr_stage_chk #(
  .OFF_W(OFF_W), .REG_OFF(REG_OFF), .EP_W(EP_W)
) u_chk (.*);

// File: tb/usb_addr_stage_bench.sv
module usb_addr_stage_bench;
  localparam int N = 12;
  // op: 0 idle, 1 write, 2 in_done, 3 bus reset
  localparam logic [1:0]  OP  [N] = '{2'd1, 2'd1, 2'd2, 2'd1, 2'd2, 2'd2,
                                       2'd1, 2'd3, 2'd2, 2'd1, 2'd1, 2'd1};
  localparam logic [6:0]  VA  [N] = '{7'h05, 7'h22, 7'h00, 7'h33, 7'h00, 7'h00,
                                       7'h7F, 7'h00, 7'h00, 7'h7F, 7'h01, 7'h10};
  localparam logic        VS  [N] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0,
                                       1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam logic [3:0]  VE  [N] = '{4'd0, 4'd0, 4'd3, 4'd0, 4'd0, 4'd0,
                                       4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0};
  localparam logic [6:0]  EA  [N] = '{7'h05, 7'h05, 7'h05, 7'h05, 7'h33, 7'h33,
                                       7'h33, 7'h00, 7'h00, 7'h7F, 7'h7F, 7'h10};
  localparam logic        EP  [N] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0,
                                       1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam string       TAG [N] = '{"R2", "R3", "R5", "R6", "R4", "R11",
                                       "R3", "R7", "R11", "R2", "R3", "R2"};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_reset_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [11:0] wr_off_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        in_done_i = 1'b0;
  logic [3:0]  in_ep_i = '0;
  logic [6:0]  dev_addr_o;
  logic        pending_o;
  logic [31:0] rd_data_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  usb_addr_stage u_usb_addr_stage (.*);

  function automatic logic [31:0] word(logic [6:0] a, logic s);
    return {a, s, 24'hA5C3E1};
  endfunction

  task automatic idle_inputs();
    bus_reset_i = 1'b0; wr_en_i = 1'b0; in_done_i = 1'b0;
    wr_off_i = '0; wr_data_i = '0; in_ep_i = '0;
  endtask

  task automatic check(string tag, logic [6:0] ea, logic ep);
    logic [31:0] er;
    er = {ea, ep, 24'h0};
    checks++;
    if (dev_addr_o !== ea || pending_o !== ep || rd_data_o !== er) begin
      fails++;
      $display("FAIL %s: addr=%h pend=%b rd=%h expected addr=%h pend=%b rd=%h",
               tag, dev_addr_o, pending_o, rd_data_o, ea, ep, er);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk_i);
    check("R1", 7'h00, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", 7'h00, 1'b0);

    for (int i = 0; i < N; i++) begin
      idle_inputs();
      case (OP[i])
        2'd1: begin wr_en_i = 1'b1; wr_off_i = 12'h144; wr_data_i = word(VA[i], VS[i]); end
        2'd2: begin in_done_i = 1'b1; in_ep_i = VE[i]; end
        2'd3: bus_reset_i = 1'b1;
        default: ;
      endcase
      @(negedge clk_i);
      idle_inputs();
      check(TAG[i], EA[i], EP[i]);
    end

    // R9: write at another offset ignored (both modes)
    wr_en_i = 1'b1; wr_off_i = 12'h148; wr_data_i = word(7'h2A, 1'b0);
    @(negedge clk_i); idle_inputs();
    check("R9", 7'h10, 1'b0);
    wr_en_i = 1'b1; wr_off_i = 12'h140; wr_data_i = word(7'h2B, 1'b1);
    @(negedge clk_i); idle_inputs();
    check("R9", 7'h10, 1'b0);

    // R10: staged write in same cycle as ep0 commit -> new pending, no commit
    wr_en_i = 1'b1; wr_off_i = 12'h144; wr_data_i = word(7'h44, 1'b1);
    @(negedge clk_i); idle_inputs();
    wr_en_i = 1'b1; wr_off_i = 12'h144; wr_data_i = word(7'h55, 1'b1);
    in_done_i = 1'b1; in_ep_i = 4'd0;
    @(negedge clk_i); idle_inputs();
    check("R10", 7'h10, 1'b1);
    in_done_i = 1'b1;
    @(negedge clk_i); idle_inputs();
    check("R6", 7'h55, 1'b0);

    // R10: immediate write with ep0 commit -> write wins
    wr_en_i = 1'b1; wr_off_i = 12'h144; wr_data_i = word(7'h66, 1'b1);
    @(negedge clk_i); idle_inputs();
    wr_en_i = 1'b1; wr_off_i = 12'h144; wr_data_i = word(7'h09, 1'b0);
    in_done_i = 1'b1;
    @(negedge clk_i); idle_inputs();
    check("R10", 7'h09, 1'b0);

    // R7: bus reset beats a simultaneous write
    wr_en_i = 1'b1; wr_off_i = 12'h144; wr_data_i = word(7'h3C, 1'b0);
    bus_reset_i = 1'b1;
    @(negedge clk_i); idle_inputs();
    check("R7", 7'h00, 1'b0);

    // R5: every non-zero endpoint leaves a pending value alone
    wr_en_i = 1'b1; wr_off_i = 12'h144; wr_data_i = word(7'h5A, 1'b1);
    @(negedge clk_i); idle_inputs();
    for (int e = 1; e < 16; e++) begin
      in_done_i = 1'b1; in_ep_i = 4'(e);
      @(negedge clk_i); idle_inputs();
    end
    check("R5", 7'h00, 1'b1);
    in_done_i = 1'b1;
    @(negedge clk_i); idle_inputs();
    check("R4", 7'h5A, 1'b0);

    // R1: async reset mid-run
    wr_en_i = 1'b1; wr_off_i = 12'h144; wr_data_i = word(7'h11, 1'b1);
    @(negedge clk_i); idle_inputs();
    rst_ni = 1'b0;
    #5;
    check("R1", 7'h00, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", 7'h00, 1'b0);

    done = 1'b1;
    finish_run();
  end
endmodule